// File: doc/BRIEF.md
# Interrupt Delivery Path Classifier

This block decides, for one interrupt or exception, how it is to be delivered. A caller presents the processor mode bits, the current privilege level, the fields of the gate found in the interrupt table, the fields of the code segment that gate points at, the two table limits, a software-origin flag and an external-event flag, and pulses `start_i`. One cycle later the block reports either a delivery path or a fault class with a 16-bit error code. It does not fetch descriptors, push frames or switch tasks. Its only job is the verdict.

The checks form a fixed chain. Interrupt-table checks come first: range, then gate type, then gate privilege for software interrupts only, then gate presence. A task gate ends the chain there. For interrupt and trap gates the target code segment is checked next: null selector, table range, segment type, presence, and finally privilege. Only the first failing check is reported. The verdict is held until the next start.

Top module: `intd_dispatch_classify`

## Requirements
- R1: During and after reset, before any start, `valid_o`=0, `path_o`=0, `fault_o`=0 and `err_code_o`=0.
- R2: The verdict for the inputs sampled at a clock edge where `start_i`=1 appears after that edge. `valid_o` goes to 1 then and stays at 1. Outputs do not change at edges where `start_i`=0.
- R3: With `pe_i`=0 the path is real-mode (`path_o`=1), with fault 0 and error code 0, whatever the other inputs are.
- R4: If `vector_i`*8+7 > `idt_limit_i`, the fault is GP (`fault_o`=1) with error code `vector_i`*8+2+`ext_i`. Bit 0 of every error code is `ext_i`.
- R5: A gate type other than 5 (task), 6, 7, 14 or 15 (interrupt/trap gates) gives GP with the vector error code of R4.
- R6: If `sw_int_i`=1 and `gate_dpl_i` < `cpl_i`, the fault is GP with the vector error code. With `sw_int_i`=0 the gate privilege is not checked.
- R7: A gate with `gate_present_i`=0 gives NP (`fault_o`=2) with the vector error code. This check is made only after R4 to R6 pass.
- R8: A valid, present task gate (type 5) gives the task path (`path_o`=2). All target-segment inputs are ignored.
- R9: For an interrupt or trap gate, `tgt_sel_hi_i`=0 (null selector) gives GP with error code equal to `ext_i`.
- R10: If the target index*8+7 > `tgt_limit_i` (index = `tgt_sel_hi_i`[13:1]), or `tgt_is_code_i`=0, the fault is GP with selector code {`tgt_sel_hi_i`, 0, `ext_i`}.
- R11: A target with `tgt_present_i`=0 gives NP with the selector code. This check is made after R9 and R10.
- R12: A non-conforming target with `tgt_dpl_i` < `cpl_i` selects the inner-privilege path (`path_o`=4) when `vm_i`=0, and the from-V86 path (`path_o`=5) when `vm_i`=1.
- R13: A conforming target, or one with `tgt_dpl_i` = `cpl_i`, selects the same-privilege path (`path_o`=3). Otherwise the fault is GP with the selector code.
- R14: A valid verdict has exactly one of `path_o`≠0 and `fault_o`≠0. When a path is chosen the error code is 0. Fault code 3 (TS) is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Sample inputs and classify |
| pe_i | input | 1 | Protection enabled |
| vm_i | input | 1 | Virtual-8086 mode active |
| sw_int_i | input | 1 | Event caused by a software interrupt instruction |
| ext_i | input | 1 | Event of external origin; error-code bit 0 |
| vector_i | input | VEC_W | Interrupt vector number |
| idt_limit_i | input | LIM_W | Interrupt table byte limit |
| gate_type_i | input | 4 | Gate descriptor type code |
| gate_dpl_i | input | 2 | Gate privilege level |
| gate_present_i | input | 1 | Gate present |
| cpl_i | input | 2 | Current privilege level |
| tgt_sel_hi_i | input | SEL_W-2 | Target selector bits above the requested-privilege field |
| tgt_limit_i | input | LIM_W | Byte limit of the table holding the target |
| tgt_is_code_i | input | 1 | Target descriptor is a code segment |
| tgt_conforming_i | input | 1 | Target code segment is conforming |
| tgt_dpl_i | input | 2 | Target segment privilege level |
| tgt_present_i | input | 1 | Target segment present |
| valid_o | output | 1 | A verdict is held |
| path_o | output | 3 | 0 none, 1 real, 2 task, 3 same, 4 inner, 5 from-V86 |
| fault_o | output | 2 | 0 none, 1 GP, 2 NP, 3 TS |
| err_code_o | output | SEL_W | Error code of the fault |

## Verification
The bench builds the block with its defaults: VEC_W=8, SEL_W=16, LIM_W=16. With an 8-bit vector it can walk every vector against its exact table-limit boundary, once just inside and once just outside. The 4-bit type field and 2-bit privilege fields are small enough that every gate type, every gate and target privilege against every current level, and every mix of conforming, code, present and mode flags are swept in full. The three selector classes (null, in range, beyond the limit) are crossed with all of these.

// File: rtl/intd_pkg.sv
// Shared types for the interrupt delivery classifier.
// Assumes error codes are as wide as a selector.
package intd_pkg;

    typedef enum logic [2:0] {
        PATH_NONE  = 3'd0,
        PATH_REAL  = 3'd1,
        PATH_TASK  = 3'd2,
        PATH_SAME  = 3'd3,
        PATH_INNER = 3'd4,
        PATH_V86   = 3'd5
    } path_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2,
        FLT_TS   = 2'd3
    } fault_e;

    localparam logic [3:0] GT_TASK   = 4'h5;
    localparam logic [3:0] GT_INT16  = 4'h6;
    localparam logic [3:0] GT_TRAP16 = 4'h7;
    localparam logic [3:0] GT_INT32  = 4'hE;
    localparam logic [3:0] GT_TRAP32 = 4'hF;

endpackage

// File: rtl/intd_gate_check.sv
// Interrupt-table stage: checks vector range, gate type, gate privilege
// (software events only) and gate presence, in that order.
// Assumes SEL_W > VEC_W + 3 so the vector error code fits.
module intd_gate_check
    import intd_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int LIM_W = 16,
    parameter int SEL_W = 16
) (
    input  logic [VEC_W-1:0] vector_i,
    input  logic [LIM_W-1:0] idt_limit_i,
    input  logic [3:0]       gate_type_i,
    input  logic [1:0]       gate_dpl_i,
    input  logic             gate_present_i,
    input  logic             sw_int_i,
    input  logic [1:0]       cpl_i,
    input  logic             ext_i,
    output fault_e           gate_fault_o,
    output logic [SEL_W-1:0] gate_err_o,
    output logic             is_task_o
);
    localparam int CMP_W = LIM_W + VEC_W + 3;
    localparam int VPAD  = SEL_W - VEC_W - 3;

    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] limit_ext;
    logic             out_of_table;
    logic             type_ok;
    logic             priv_bad;

    // Widen both sides of the table range comparison.
    always_comb begin
        last_byte = {{LIM_W{1'b0}}, vector_i, 3'b111};
        limit_ext = {{(VEC_W + 3){1'b0}}, idt_limit_i};
    end

    // Decode the individual gate conditions.
    always_comb begin
        out_of_table = last_byte > limit_ext;
        type_ok      = (gate_type_i == GT_TASK)   || (gate_type_i == GT_INT16)  ||
                       (gate_type_i == GT_TRAP16) || (gate_type_i == GT_INT32)  ||
                       (gate_type_i == GT_TRAP32);
        priv_bad     = sw_int_i && (gate_dpl_i < cpl_i);
        is_task_o    = gate_type_i == GT_TASK;
    end

    // Priority chain: first failing gate check wins.
    always_comb begin
        gate_err_o = {{VPAD{1'b0}}, vector_i, 2'b01, ext_i};
        if (out_of_table || !type_ok || priv_bad) begin
            gate_fault_o = FLT_GP;
        end else if (!gate_present_i) begin
            gate_fault_o = FLT_NP;
        end else begin
            gate_fault_o = FLT_NONE;
        end
    end

    // A hardware event never fails on gate privilege alone.
    always_comb begin
        if (!sw_int_i && !out_of_table && type_ok && gate_present_i) begin
            p_hw_skip_dpl_r6: assert (gate_fault_o == FLT_NONE);
        end
        if (!gate_present_i) begin
            p_absent_gate_r7: assert (gate_fault_o != FLT_NONE);
        end
    end

endmodule

// File: rtl/intd_target_check.sv
// Code-segment stage for interrupt and trap gates: null selector, table
// range, segment type, presence, then privilege selects a path.
// Assumes selector bit 0 of tgt_sel_hi_i is the table indicator.
module intd_target_check
    import intd_pkg::*;
#(
    parameter int LIM_W = 16,
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-3:0] tgt_sel_hi_i,
    input  logic [LIM_W-1:0] tgt_limit_i,
    input  logic             tgt_is_code_i,
    input  logic             tgt_conforming_i,
    input  logic [1:0]       tgt_dpl_i,
    input  logic             tgt_present_i,
    input  logic [1:0]       cpl_i,
    input  logic             vm_i,
    input  logic             ext_i,
    output fault_e           tgt_fault_o,
    output logic [SEL_W-1:0] tgt_err_o,
    output path_e            tgt_path_o
);
    localparam int CMP_W = LIM_W + SEL_W;

    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] limit_ext;
    logic             is_null;
    logic             out_of_table;
    logic             to_inner;
    logic             to_same;

    // Widen both sides of the descriptor range comparison.
    always_comb begin
        last_byte = {{LIM_W{1'b0}}, tgt_sel_hi_i[SEL_W-3:1], 3'b111};
        limit_ext = {{SEL_W{1'b0}}, tgt_limit_i};
    end

    // Decode the individual target conditions.
    always_comb begin
        is_null      = tgt_sel_hi_i == '0;
        out_of_table = last_byte > limit_ext;
        to_inner     = !tgt_conforming_i && (tgt_dpl_i < cpl_i);
        to_same      = tgt_conforming_i || (tgt_dpl_i == cpl_i);
    end

    // Priority chain over the target checks, then path choice.
    always_comb begin
        tgt_path_o  = PATH_NONE;
        tgt_fault_o = FLT_NONE;
        tgt_err_o   = {tgt_sel_hi_i, 1'b0, ext_i};
        if (is_null) begin
            tgt_fault_o = FLT_GP;
            tgt_err_o   = {{(SEL_W-1){1'b0}}, ext_i};
        end else if (out_of_table || !tgt_is_code_i) begin
            tgt_fault_o = FLT_GP;
        end else if (!tgt_present_i) begin
            tgt_fault_o = FLT_NP;
        end else if (to_inner) begin
            tgt_path_o  = vm_i ? PATH_V86 : PATH_INNER;
        end else if (to_same) begin
            tgt_path_o  = PATH_SAME;
        end else begin
            tgt_fault_o = FLT_GP;
        end
    end

    // A fully valid, more-privileged non-conforming target never faults.
    always_comb begin
        if (!is_null && !out_of_table && tgt_is_code_i && tgt_present_i &&
            !tgt_conforming_i && (tgt_dpl_i < cpl_i)) begin
            p_inner_select_r12: assert (tgt_fault_o == FLT_NONE &&
                                        (tgt_path_o == PATH_INNER || tgt_path_o == PATH_V86));
        end
        if (is_null) begin
            p_null_code_r9: assert (tgt_err_o[SEL_W-1:1] == '0);
        end
    end

endmodule

// File: rtl/intd_verdict_reg.sv
// Holds the verdict: loads on start, otherwise keeps it.
// Assumes start_i is a single-cycle request from the caller.
module intd_verdict_reg
    import intd_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  path_e            path_d,
    input  fault_e           fault_d,
    input  logic [SEL_W-1:0] err_d,
    output logic             valid_o,
    output path_e            path_q,
    output fault_e           fault_q,
    output logic [SEL_W-1:0] err_q
);

    // Capture the new verdict on start; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            path_q  <= PATH_NONE;
            fault_q <= FLT_NONE;
            err_q   <= '0;
        end else if (start_i) begin
            valid_o <= 1'b1;
            path_q  <= path_d;
            fault_q <= fault_d;
            err_q   <= err_d;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(path_q) && $stable(fault_q) && $stable(err_q) && $stable(valid_o)));

    p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

endmodule

// File: rtl/intd_dispatch_classify.sv
// Top of the interrupt delivery classifier: combines the mode bit, the
// gate stage and the target stage into one verdict, registered on start.
// Assumes all descriptor fields are already fetched and stable with start.
module intd_dispatch_classify
    import intd_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int SEL_W = 16,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pe_i,
    input  logic             vm_i,
    input  logic             sw_int_i,
    input  logic             ext_i,
    input  logic [VEC_W-1:0] vector_i,
    input  logic [LIM_W-1:0] idt_limit_i,
    input  logic [3:0]       gate_type_i,
    input  logic [1:0]       gate_dpl_i,
    input  logic             gate_present_i,
    input  logic [1:0]       cpl_i,
    input  logic [SEL_W-3:0] tgt_sel_hi_i,
    input  logic [LIM_W-1:0] tgt_limit_i,
    input  logic             tgt_is_code_i,
    input  logic             tgt_conforming_i,
    input  logic [1:0]       tgt_dpl_i,
    input  logic             tgt_present_i,
    output logic             valid_o,
    output logic [2:0]       path_o,
    output logic [1:0]       fault_o,
    output logic [SEL_W-1:0] err_code_o
);

    fault_e           gate_fault;
    logic [SEL_W-1:0] gate_err;
    logic             gate_is_task;
    fault_e           tgt_fault;
    logic [SEL_W-1:0] tgt_err;
    path_e            tgt_path;
    path_e            path_d;
    fault_e           fault_d;
    logic [SEL_W-1:0] err_d;
    path_e            path_q;
    fault_e           fault_q;

    intd_gate_check #(
        .VEC_W(VEC_W), .LIM_W(LIM_W), .SEL_W(SEL_W)
    ) gate_chk_i (
        .vector_i       (vector_i),
        .idt_limit_i    (idt_limit_i),
        .gate_type_i    (gate_type_i),
        .gate_dpl_i     (gate_dpl_i),
        .gate_present_i (gate_present_i),
        .sw_int_i       (sw_int_i),
        .cpl_i          (cpl_i),
        .ext_i          (ext_i),
        .gate_fault_o   (gate_fault),
        .gate_err_o     (gate_err),
        .is_task_o      (gate_is_task)
    );

    intd_target_check #(
        .LIM_W(LIM_W), .SEL_W(SEL_W)
    ) tgt_chk_i (
        .tgt_sel_hi_i     (tgt_sel_hi_i),
        .tgt_limit_i      (tgt_limit_i),
        .tgt_is_code_i    (tgt_is_code_i),
        .tgt_conforming_i (tgt_conforming_i),
        .tgt_dpl_i        (tgt_dpl_i),
        .tgt_present_i    (tgt_present_i),
        .cpl_i            (cpl_i),
        .vm_i             (vm_i),
        .ext_i            (ext_i),
        .tgt_fault_o      (tgt_fault),
        .tgt_err_o        (tgt_err),
        .tgt_path_o       (tgt_path)
    );

    // Merge stages: real mode, then gate faults, then task, then target.
    always_comb begin
        path_d  = PATH_NONE;
        fault_d = FLT_NONE;
        err_d   = '0;
        if (!pe_i) begin
            path_d  = PATH_REAL;
        end else if (gate_fault != FLT_NONE) begin
            fault_d = gate_fault;
            err_d   = gate_err;
        end else if (gate_is_task) begin
            path_d  = PATH_TASK;
        end else if (tgt_fault != FLT_NONE) begin
            fault_d = tgt_fault;
            err_d   = tgt_err;
        end else begin
            path_d  = tgt_path;
        end
    end

    intd_verdict_reg #(
        .SEL_W(SEL_W)
    ) verdict_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .path_d  (path_d),
        .fault_d (fault_d),
        .err_d   (err_d),
        .valid_o (valid_o),
        .path_q  (path_q),
        .fault_q (fault_q),
        .err_q   (err_code_o)
    );

    // Drive the plain output ports from the typed register state.
    always_comb begin
        path_o  = path_q;
        fault_o = fault_q;
    end

    p_real_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !pe_i) |=> (path_o == PATH_REAL && fault_o == FLT_NONE && err_code_o == '0));

    p_ext_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (fault_o == FLT_NONE || err_code_o[0] == $past(ext_i)));

    p_one_outcome_r14: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((fault_o == FLT_NONE) != (path_o == PATH_NONE)) && fault_o != FLT_TS);

    p_task_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && pe_i && gate_fault == FLT_NONE && gate_type_i == GT_TASK) |=> path_o == PATH_TASK);

endmodule

// File: tb/intd_dispatch_classify_tb_top.sv
// Sweeping bench for the interrupt delivery classifier.
module intd_dispatch_classify_tb_top;

    localparam int VEC_W = 8;
    localparam int SEL_W = 16;
    localparam int LIM_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             pe_i = 1'b1;
    logic             vm_i = 1'b0;
    logic             sw_int_i = 1'b0;
    logic             ext_i = 1'b0;
    logic [VEC_W-1:0] vector_i = '0;
    logic [LIM_W-1:0] idt_limit_i = 16'h07FF;
    logic [3:0]       gate_type_i = 4'hE;
    logic [1:0]       gate_dpl_i = 2'd0;
    logic             gate_present_i = 1'b1;
    logic [1:0]       cpl_i = 2'd0;
    logic [SEL_W-3:0] tgt_sel_hi_i = 14'h0012;
    logic [LIM_W-1:0] tgt_limit_i = 16'h00FF;
    logic             tgt_is_code_i = 1'b1;
    logic             tgt_conforming_i = 1'b0;
    logic [1:0]       tgt_dpl_i = 2'd0;
    logic             tgt_present_i = 1'b1;
    logic             valid_o;
    logic [2:0]       path_o;
    logic [1:0]       fault_o;
    logic [SEL_W-1:0] err_code_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    intd_dispatch_classify #(
        .VEC_W(VEC_W), .SEL_W(SEL_W), .LIM_W(LIM_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pe_i(pe_i), .vm_i(vm_i), .sw_int_i(sw_int_i), .ext_i(ext_i),
        .vector_i(vector_i), .idt_limit_i(idt_limit_i),
        .gate_type_i(gate_type_i), .gate_dpl_i(gate_dpl_i),
        .gate_present_i(gate_present_i), .cpl_i(cpl_i),
        .tgt_sel_hi_i(tgt_sel_hi_i), .tgt_limit_i(tgt_limit_i),
        .tgt_is_code_i(tgt_is_code_i), .tgt_conforming_i(tgt_conforming_i),
        .tgt_dpl_i(tgt_dpl_i), .tgt_present_i(tgt_present_i),
        .valid_o(valid_o), .path_o(path_o), .fault_o(fault_o),
        .err_code_o(err_code_o)
    );

    // Expected verdict computed from the requirement list.
    function automatic void expect_verdict(output logic [2:0] p, output logic [1:0] f,
                                           output logic [15:0] e, output string rule);
        int vcode;
        int scode;
        vcode = int'(vector_i) * 8 + 2 + int'(ext_i);
        scode = int'(tgt_sel_hi_i) * 4 + int'(ext_i);
        p = 3'd0; f = 2'd0; e = 16'd0;
        if (!pe_i) begin
            p = 3'd1; rule = "R3";
        end else if (int'(vector_i) * 8 + 7 > int'(idt_limit_i)) begin
            f = 2'd1; e = 16'(vcode); rule = "R4";
        end else if (!(gate_type_i == 4'd5 || gate_type_i == 4'd6 || gate_type_i == 4'd7 ||
                       gate_type_i == 4'd14 || gate_type_i == 4'd15)) begin
            f = 2'd1; e = 16'(vcode); rule = "R5";
        end else if (sw_int_i && gate_dpl_i < cpl_i) begin
            f = 2'd1; e = 16'(vcode); rule = "R6";
        end else if (!gate_present_i) begin
            f = 2'd2; e = 16'(vcode); rule = "R7";
        end else if (gate_type_i == 4'd5) begin
            p = 3'd2; rule = "R8";
        end else if (tgt_sel_hi_i == '0) begin
            f = 2'd1; e = 16'(ext_i); rule = "R9";
        end else if (int'(tgt_sel_hi_i >> 1) * 8 + 7 > int'(tgt_limit_i) || !tgt_is_code_i) begin
            f = 2'd1; e = 16'(scode); rule = "R10";
        end else if (!tgt_present_i) begin
            f = 2'd2; e = 16'(scode); rule = "R11";
        end else if (!tgt_conforming_i && tgt_dpl_i < cpl_i) begin
            p = vm_i ? 3'd5 : 3'd4; rule = "R12";
        end else if (tgt_conforming_i || tgt_dpl_i == cpl_i) begin
            p = 3'd3; rule = "R13";
        end else begin
            f = 2'd1; e = 16'(scode); rule = "R13";
        end
    endfunction

    task automatic check_outputs(string rule, logic v, logic [2:0] p, logic [1:0] f, logic [15:0] e);
        n_tests++;
        if (valid_o !== v || path_o !== p || fault_o !== f || err_code_o !== e) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b path=%0d fault=%0d err=%h, expected valid=%0b path=%0d fault=%0d err=%h",
                     rule, valid_o, path_o, fault_o, err_code_o, v, p, f, e);
        end
    endtask

    // Pulse start for one cycle and compare the registered verdict.
    task automatic run_case();
        logic [2:0]  p;
        logic [1:0]  f;
        logic [15:0] e;
        string       rule;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        expect_verdict(p, f, e, rule);
        check_outputs(rule, 1'b1, p, f, e);
    endtask

    task automatic set_good_target();
        tgt_sel_hi_i = 14'h0012; tgt_limit_i = 16'h00FF; tgt_is_code_i = 1'b1;
        tgt_conforming_i = 1'b0; tgt_dpl_i = 2'd0; tgt_present_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outputs("R1", 1'b0, 3'd0, 2'd0, 16'd0);   // R1 reset state
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_outputs("R1", 1'b0, 3'd0, 2'd0, 16'd0);   // R1 idle before start

        // R2: first verdict, then inputs change without start
        pe_i = 1'b1; cpl_i = 2'd3; gate_type_i = 4'hE; set_good_target();
        run_case();
        gate_present_i = 1'b0; pe_i = 1'b0;
        repeat (3) @(negedge clk);
        check_outputs("R2", 1'b1, 3'd4, 2'd0, 16'd0);
        gate_present_i = 1'b1; pe_i = 1'b1;

        // R3: real mode ignores all other inputs
        for (int i = 0; i < 64; i++) begin
            pe_i = 1'b0; vm_i = i[0]; sw_int_i = i[1]; ext_i = i[2];
            gate_type_i = 4'(i * 7); gate_present_i = i[3]; cpl_i = 2'(i);
            vector_i = 8'(i * 37); idt_limit_i = 16'(i);
            tgt_sel_hi_i = 14'(i[5:4]); tgt_is_code_i = i[4];
            run_case();
        end
        pe_i = 1'b1;

        // R4: every vector at its exact table-limit boundary
        gate_type_i = 4'h6; gate_present_i = 1'b1; sw_int_i = 1'b0; cpl_i = 2'd0;
        set_good_target();
        for (int v = 0; v < 256; v++) begin
            vector_i = 8'(v); ext_i = v[0];
            idt_limit_i = 16'(v * 8 + 7);
            run_case();
            idt_limit_i = 16'(v * 8 + 6);
            run_case();
        end

        // R5 R6 R7 R8: gate type, privilege, presence sweep
        idt_limit_i = 16'h07FF;
        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 16; t++)
                for (int gd = 0; gd < 4; gd++)
                    for (int gp = 0; gp < 2; gp++)
                        for (int c = 0; c < 4; c++) begin
                            sw_int_i = s[0]; gate_type_i = 4'(t); gate_dpl_i = 2'(gd);
                            gate_present_i = gp[0]; cpl_i = 2'(c);
                            ext_i = 1'(t + c); vector_i = 8'(t * 16 + gd * 4 + c);
                            tgt_dpl_i = 2'(3 - c);
                            run_case();
                        end

        // R8 to R13: target-segment sweep across gate kinds and modes
        sw_int_i = 1'b0; gate_present_i = 1'b1; gate_dpl_i = 2'd3; vector_i = 8'h21;
        for (int g = 0; g < 3; g++)
            for (int c = 0; c < 4; c++)
                for (int td = 0; td < 4; td++)
                    for (int m = 0; m < 16; m++)
                        for (int sc = 0; sc < 3; sc++)
                            for (int x = 0; x < 2; x++) begin
                                gate_type_i = (g == 0) ? 4'h6 : ((g == 1) ? 4'hF : 4'h5);
                                cpl_i = 2'(c); tgt_dpl_i = 2'(td);
                                tgt_conforming_i = m[0]; tgt_is_code_i = m[1];
                                tgt_present_i = m[2]; vm_i = m[3]; ext_i = x[0];
                                tgt_sel_hi_i = (sc == 0) ? 14'h0000 :
                                               ((sc == 1) ? 14'h0012 : 14'h0051);
                                run_case();
                            end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule